// File: doc/BRIEF.md
# Sweep Gate Controller

This block decides when the horizontal sweep of a scope timebase may start. When a sweep ends, a holdoff interval runs for a number of clock cycles set by a two-bit timebase range select. While holdoff runs, or while the external ramp has not finished resetting, a two-stage arming chain stays clear. Once it is released, a low trigger level arms the first stage. The next rising trigger edge then sets the gate stage, which drives the sweep gate output.

In auto mode, a watchdog counter raises an auto-baseline flag when no trigger edges arrive for a programmable number of cycles. While the flag is up, the gate stage sets itself as soon as the chain is released, so the sweep free-runs once per holdoff. X-Y mode blocks holdoff from starting and keeps both stages clear. A one-cycle sync pulse marks the start of every holdoff interval.

Top module: `sweep_gate_ctrl`

## Requirements
- R1: An end-of-sweep pulse on `eos_i`, sampled while holdoff is idle and X-Y mode is off, starts holdoff. `holdoff_o` then stays high for exactly `HOLDOFF_BASE << (2*range_sel_i)` cycles, using the range value sampled with the pulse. With the default base of 4, the codes 0, 1, 2 and 3 give 4, 16, 64 and 256 cycles.
- R2: `sync_pulse_o` is high for exactly one cycle, and that cycle is the first cycle of `holdoff_o`.
- R3: From the cycle after holdoff starts until holdoff ends, `sweep_gate_o` is low. Trigger edges that occur during holdoff do not arm or fire the chain.
- R4: The chain is released only when holdoff is idle and `ramp_reset_done_i` is high. While `ramp_reset_done_i` is low, a rising trigger edge does not assert the gate.
- R5: Once the chain is released, the trigger must first be low (this arms the first stage). The next rising trigger edge then asserts `sweep_gate_o`, three clock edges after `trig_i` rises.
- R6: If the trigger is already low at the moment of release, the first stage arms without a new falling edge, and the next rising edge fires the gate.
- R7: In auto mode, `auto_base_o` rises after `AUTO_TIMEOUT` cycles with no trigger edge. Any synchronized trigger edge clears it. It stays low whenever `auto_mode_i` is low.
- R8: While `auto_base_o` is high, the gate sets on the second clock edge after holdoff ends, with no trigger edge needed.
- R9: While `xy_mode_i` is high, no holdoff starts, no sync pulse appears, and `sweep_gate_o` is low from the next cycle on.
- R10: `ramp_reset_o` is always the inverse of `sweep_gate_o`.
- R11: During reset, `sweep_gate_o`, `holdoff_o`, `sync_pulse_o` and `auto_base_o` are low and `ramp_reset_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Asynchronous trigger comparator output |
| eos_i | input | 1 | End-of-sweep pulse; starts holdoff |
| ramp_reset_done_i | input | 1 | High when the ramp has finished resetting |
| range_sel_i | input | 2 | Timebase range code that picks the holdoff length |
| auto_mode_i | input | 1 | Enables auto free-run; low selects normal triggering |
| xy_mode_i | input | 1 | X-Y display lockout |
| sweep_gate_o | output | 1 | Sweep gate; high while a sweep is allowed to run |
| ramp_reset_o | output | 1 | Holds the ramp in reset while high |
| holdoff_o | output | 1 | High while holdoff is running |
| sync_pulse_o | output | 1 | One-cycle pulse at the start of holdoff |
| auto_base_o | output | 1 | Auto-baseline flag |

## Verification
The following are checked on every cycle, whatever the bench does:
- the gate is low throughout holdoff and under X-Y lockout;
- every rise of the gate follows a cycle in which holdoff was idle and the ramp reset was complete;
- each sync pulse lines up with the first holdoff cycle;
- every holdoff interval has the length given by its captured range code;
- the auto flag stays down in normal mode.

Some behaviour can only be shown by the bench's scenarios:
- the falling-then-rising arming order;
- the three-edge trigger latency;
- staying armed when the trigger is already low at release;
- the auto timeout count;
- free-run after holdoff.

// File: rtl/sweep_gate_pkg.sv
package sweep_gate_pkg;
  typedef logic [1:0] range_sel_t;

  // Holdoff grows by 4x per range step
  function automatic int unsigned holdoff_len(int unsigned base, range_sel_t sel);
    return base << (2 * int'(sel));
  endfunction
endpackage

// File: rtl/sg_trig_edge.sv
module sg_trig_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], trig_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/sg_holdoff_timer.sv
module sg_holdoff_timer
  import sweep_gate_pkg::*;
#(
  parameter int unsigned HOLDOFF_BASE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  range_sel_t range_sel_i,
  output logic       busy_o,
  output logic       start_pulse_o
);
  localparam int unsigned MAX_LEN = HOLDOFF_BASE << 6;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, pulse_q;
  logic          start_ok;

  assign start_ok = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= start_ok;
      if (start_ok) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(holdoff_len(HOLDOFF_BASE, range_sel_i) - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o        = busy_q;
  assign start_pulse_o = pulse_q;
endmodule

// File: rtl/sg_auto_timer.sv
module sg_auto_timer #(
  parameter int unsigned AUTO_TIMEOUT = 20_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic edge_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(AUTO_TIMEOUT + 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (!enable_i || edge_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cnt_q == CW'(AUTO_TIMEOUT - 1)) begin
      flag_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sweep_gate_ctrl.sv
module sweep_gate_ctrl
  import sweep_gate_pkg::*;
#(
  parameter int unsigned HOLDOFF_BASE = 4,
  parameter int unsigned AUTO_TIMEOUT = 20_000_000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic       eos_i,
  input  logic       ramp_reset_done_i,
  input  logic [1:0] range_sel_i,
  input  logic       auto_mode_i,
  input  logic       xy_mode_i,
  output logic       sweep_gate_o,
  output logic       ramp_reset_o,
  output logic       holdoff_o,
  output logic       sync_pulse_o,
  output logic       auto_base_o
);
  logic trig_lvl, trig_rise, trig_fall;
  logic hold_busy, auto_flag;
  logic chain_clr;
  logic arm_q, gate_q;

  sg_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .lvl_o  (trig_lvl),
    .rise_o (trig_rise),
    .fall_o (trig_fall)
  );

  sg_holdoff_timer #(.HOLDOFF_BASE(HOLDOFF_BASE)) u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (eos_i & ~xy_mode_i),
    .range_sel_i   (range_sel_t'(range_sel_i)),
    .busy_o        (hold_busy),
    .start_pulse_o (sync_pulse_o)
  );

  sg_auto_timer #(.AUTO_TIMEOUT(AUTO_TIMEOUT)) u_auto (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (auto_mode_i),
    .edge_i   (trig_rise | trig_fall),
    .flag_o   (auto_flag)
  );

  // Both stages held clear by holdoff, unfinished ramp reset or X-Y lockout
  assign chain_clr = hold_busy | ~ramp_reset_done_i | xy_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (chain_clr) begin
      arm_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      // Low trigger level arms; stays armed if already low at release
      arm_q  <= arm_q | ~trig_lvl;
      gate_q <= gate_q | (arm_q & trig_rise) | auto_flag;
    end
  end

  assign sweep_gate_o = gate_q;
  assign ramp_reset_o = ~gate_q;
  assign holdoff_o    = hold_busy;
  assign auto_base_o  = auto_flag;
endmodule

// File: rtl/sweep_gate_chk.sv
module sweep_gate_chk
  import sweep_gate_pkg::*;
#(
  parameter int unsigned HOLDOFF_BASE = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ramp_reset_done_i,
  input logic [1:0] range_sel_i,
  input logic       auto_mode_i,
  input logic       xy_mode_i,
  input logic       sweep_gate_o,
  input logic       holdoff_o,
  input logic       sync_pulse_o,
  input logic       auto_base_o
);
  logic       hold_d;
  logic [1:0] range_d, sel_cap;
  int         hcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_d  <= 1'b0;
      range_d <= '0;
      sel_cap <= '0;
      hcnt    <= 0;
    end else begin
      hold_d  <= holdoff_o;
      range_d <= range_sel_i;
      if (holdoff_o && !hold_d) begin
        sel_cap <= range_d;
        hcnt    <= 1;
      end else if (holdoff_o) begin
        hcnt <= hcnt + 1;
      end
    end
  end

  AST_HOLDOFF_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_d && !holdoff_o) |-> (hcnt == int'(holdoff_len(HOLDOFF_BASE, sel_cap)))); // R1
  AST_SYNC_ONLY_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_o |-> $rose(holdoff_o)); // R2
  AST_START_HAS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(holdoff_o) |-> sync_pulse_o); // R2
  AST_GATE_LOW_IN_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holdoff_o |=> !sweep_gate_o); // R3
  AST_RELEASE_NEEDS_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sweep_gate_o) |-> ($past(ramp_reset_done_i) && !$past(holdoff_o))); // R4
  AST_AUTO_OFF_IN_NORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_mode_i |=> !auto_base_o); // R7
  AST_XY_NO_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(holdoff_o) |-> !$past(xy_mode_i)); // R9
  AST_XY_GATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xy_mode_i |=> !sweep_gate_o); // R9
endmodule

bind sweep_gate_ctrl sweep_gate_chk #(.HOLDOFF_BASE(HOLDOFF_BASE)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .ramp_reset_done_i (ramp_reset_done_i),
  .range_sel_i       (range_sel_i),
  .auto_mode_i       (auto_mode_i),
  .xy_mode_i         (xy_mode_i),
  .sweep_gate_o      (sweep_gate_o),
  .holdoff_o         (holdoff_o),
  .sync_pulse_o      (sync_pulse_o),
  .auto_base_o       (auto_base_o)
);

// File: tb/sweep_gate_ctrl_tb_top.sv
module sweep_gate_ctrl_tb_top;
  localparam realtime     CLK_P  = 5ns;
  localparam int unsigned H_BASE = 4;
  localparam int unsigned AUTO_T = 200;
  localparam int unsigned EXP_LEN [4] = '{4, 16, 64, 256};

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       trig_i, eos_i, ramp_reset_done_i, auto_mode_i, xy_mode_i;
  logic [1:0] range_sel_i;
  logic       sweep_gate_o, ramp_reset_o, holdoff_o, sync_pulse_o, auto_base_o;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 1'b0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  sweep_gate_ctrl #(.HOLDOFF_BASE(H_BASE), .AUTO_TIMEOUT(AUTO_T)) dut_i (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .trig_i            (trig_i),
    .eos_i             (eos_i),
    .ramp_reset_done_i (ramp_reset_done_i),
    .range_sel_i       (range_sel_i),
    .auto_mode_i       (auto_mode_i),
    .xy_mode_i         (xy_mode_i),
    .sweep_gate_o      (sweep_gate_o),
    .ramp_reset_o      (ramp_reset_o),
    .holdoff_o         (holdoff_o),
    .sync_pulse_o      (sync_pulse_o),
    .auto_base_o       (auto_base_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_eos();
    eos_i = 1'b1;
    cyc(1);
    eos_i = 1'b0;
  endtask

  task automatic wait_holdoff_end();
    for (int i = 0; i < 400 && holdoff_o; i++) cyc(1);
  endtask

  task automatic fire_trigger();
    trig_i = 1'b0;
    cyc(4);
    trig_i = 1'b1;
    cyc(3);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int len;
    rst_ni = 1'b0; trig_i = 1'b1; eos_i = 1'b0; ramp_reset_done_i = 1'b1;
    range_sel_i = 2'd0; auto_mode_i = 1'b0; xy_mode_i = 1'b0;
    cyc(3);
    chk("R11", "gate in reset", int'(sweep_gate_o), 0);
    chk("R11", "ramp_reset in reset", int'(ramp_reset_o), 1);
    chk("R11", "holdoff in reset", int'(holdoff_o), 0);
    chk("R11", "sync in reset", int'(sync_pulse_o), 0);
    chk("R11", "auto in reset", int'(auto_base_o), 0);
    rst_ni = 1'b1;
    cyc(2);

    // Holdoff length table walk (R1, R2)
    for (int r = 0; r < 4; r++) begin
      range_sel_i = 2'(r);
      pulse_eos();
      chk("R2", "sync at start", int'(sync_pulse_o), 1);
      len = 0;
      while (holdoff_o && len < 1000) begin
        len++;
        cyc(1);
        if (len == 1) chk("R2", "sync one cycle", int'(sync_pulse_o), 0);
      end
      chk("R1", $sformatf("holdoff length range %0d", r), len, int'(EXP_LEN[r]));
      cyc(2);
    end

    // Arm on low, fire on rise (R5, R10)
    range_sel_i = 2'd1;
    trig_i = 1'b0;
    cyc(4);
    trig_i = 1'b1;
    cyc(2);
    chk("R5", "gate before third edge", int'(sweep_gate_o), 0);
    cyc(1);
    chk("R5", "gate on third edge", int'(sweep_gate_o), 1);
    chk("R10", "ramp_reset when gate high", int'(ramp_reset_o), 0);

    // Holdoff clears gate, trigger edges inside holdoff ignored (R3)
    pulse_eos();
    chk("R3", "holdoff running", int'(holdoff_o), 1);
    cyc(1);
    chk("R3", "gate cleared in holdoff", int'(sweep_gate_o), 0);
    chk("R10", "ramp_reset when gate low", int'(ramp_reset_o), 1);
    trig_i = 1'b0;
    cyc(3);
    trig_i = 1'b1;
    wait_holdoff_end();
    cyc(10);
    chk("R3", "edges in holdoff ignored", int'(sweep_gate_o), 0);
    fire_trigger();
    chk("R5", "fresh arm and fire", int'(sweep_gate_o), 1);

    // Ramp reset pending blocks release; low at release stays armed (R4, R6)
    ramp_reset_done_i = 1'b0;
    pulse_eos();
    trig_i = 1'b0;
    wait_holdoff_end();
    cyc(6);
    trig_i = 1'b1;
    cyc(6);
    chk("R4", "no fire while ramp resetting", int'(sweep_gate_o), 0);
    trig_i = 1'b0;
    cyc(6);
    ramp_reset_done_i = 1'b1;
    cyc(3);
    trig_i = 1'b1;
    cyc(3);
    chk("R6", "armed by low level at release", int'(sweep_gate_o), 1);

    // Auto baseline (R7, R8)
    auto_mode_i = 1'b1;
    cyc(AUTO_T - 20);
    chk("R7", "auto flag before timeout", int'(auto_base_o), 0);
    cyc(40);
    chk("R7", "auto flag after timeout", int'(auto_base_o), 1);
    pulse_eos();
    cyc(1);
    chk("R3", "gate low in auto holdoff", int'(sweep_gate_o), 0);
    wait_holdoff_end();
    chk("R8", "gate low on holdoff end", int'(sweep_gate_o), 0);
    cyc(1);
    chk("R8", "free-run gate", int'(sweep_gate_o), 1);
    pulse_eos();
    wait_holdoff_end();
    cyc(1);
    chk("R8", "second free-run gate", int'(sweep_gate_o), 1);
    trig_i = 1'b0;
    cyc(4);
    chk("R7", "trigger edge clears auto flag", int'(auto_base_o), 0);
    trig_i = 1'b1;
    cyc(2);
    auto_mode_i = 1'b0;
    cyc(AUTO_T + 50);
    chk("R7", "auto flag low in normal mode", int'(auto_base_o), 0);

    // X-Y lockout (R9)
    xy_mode_i = 1'b1;
    cyc(2);
    chk("R9", "gate low in x-y", int'(sweep_gate_o), 0);
    pulse_eos();
    chk("R9", "no holdoff in x-y", int'(holdoff_o), 0);
    chk("R9", "no sync in x-y", int'(sync_pulse_o), 0);
    fire_trigger();
    chk("R9", "trigger ignored in x-y", int'(sweep_gate_o), 0);
    xy_mode_i = 1'b0;
    cyc(2);

    // Reset mid-sweep (R11)
    fire_trigger();
    chk("R5", "fire after x-y", int'(sweep_gate_o), 1);
    rst_ni = 1'b0;
    cyc(1);
    chk("R11", "gate cleared by reset", int'(sweep_gate_o), 0);
    chk("R11", "ramp_reset set by reset", int'(ramp_reset_o), 1);
    rst_ni = 1'b1;
    cyc(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule